// File: doc/BRIEF.md
# Branch target and direction predictor

This block sits in the fetch stage and guesses the next fetch address every cycle. It combines two structures. A small fully associative target cache remembers where previously taken branches went. A larger direct-mapped table of 2-bit saturating counters remembers which way each branch tends to go. Given the current fetch address, the block returns a next address, a taken flag and a hit flag in the same cycle, purely from stored state.

The target cache supplies a target and, on its own, would mean "taken". The counter table has the final say: a hit whose counter leans not-taken falls back to the sequential address. When a branch executes, the resolution port reports its address, real direction and real target, and both structures learn from it at the next clock edge. Nothing is learned at prediction time.

Top module: `bpred_top`

## Requirements
- R1: The target cache has 64 entries, each compared against the full 32-bit fetch address; `pred_hit` is 1 exactly when some valid entry holds that address, and no address ever occupies two entries.
- R2: On a hit whose direction counter is 2 or 3, `pred_taken` is 1 and `pred_next_pc` is the stored target.
- R3: On a hit whose direction counter is 0 or 1, the counter overrides the cache: `pred_taken` is 0 and `pred_next_pc` is `fetch_pc + 4`.
- R4: On a miss, `pred_taken` is 0 and `pred_next_pc` is `fetch_pc + 4`, whatever the counter holds.
- R5: Each direction counter is 2 bits, starts at 1 after reset, steps up on a resolved taken branch and down on a resolved not-taken branch, and holds at 3 and at 0.
- R6: The counter table has 512 entries selected by address bits [10:2]; two branches whose addresses agree in those bits share one counter.
- R7: A resolved taken branch that hits rewrites the stored target; one that misses takes a new entry, entries being claimed in slot order 0, 1, ..., 63 and then wrapping, so the oldest allocation is the one evicted.
- R8: A resolved not-taken branch claims no entry when it misses and leaves the stored target unchanged when it hits.
- R9: State changes only at a clock edge where `res_valid` is 1; a lookup in that same cycle sees the contents from before the update, and the next cycle sees the new contents.
- R10: After reset every target cache entry is empty, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Prediction says the branch is taken |
| pred_hit | output | 1 | Fetch address found in the target cache |
| res_valid | input | 1 | A branch outcome is reported this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |
| res_target | input | 32 | Actual target of the resolved branch |

## Verification
All three prediction outputs are combinational from stored state, so they are due in the same cycle as `fetch_pc`, while a resolution becomes visible one cycle later, after the clock edge that captures it. The bench drives inputs just after a falling edge, lets them settle, compares the outputs against its behavioural model before the rising edge, and only then applies the resolution to the model at the rising edge. This ordering checks the same-cycle rule of R9 directly: a lookup of the address being updated must still return the old contents.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd1;

  // Saturating two-bit step: up on taken, down on not-taken.
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == 2'd3) ? c : c + 2'd1;
    else    r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

  // Upper half of the counter range leans taken.
  function automatic logic ctr_leans_taken(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/bpred_btc.sv
module bpred_btc #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] look_pc,
  output logic            look_hit,
  output logic [PC_W-1:0] look_tgt,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_tgt
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [IW-1:0]      rr_q;

  logic [ENTRIES-1:0] look_match;
  logic [ENTRIES-1:0] upd_match;
  logic               upd_hit;
  logic               alloc_ev;
  logic               retarget_ev;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
    assign look_match[g] = vld_q[g] && (tag_q[g] == look_pc);
    assign upd_match[g]  = vld_q[g] && (tag_q[g] == upd_pc);
  end

  always_comb begin
    look_tgt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_match[i]) look_tgt = look_tgt | tgt_q[i];
    end
  end

  assign look_hit    = |look_match;
  assign upd_hit     = |upd_match;
  assign alloc_ev    = upd_valid && upd_taken && !upd_hit;
  assign retarget_ev = upd_valid && upd_taken && upd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (alloc_ev) begin
      vld_q[rr_q] <= 1'b1;
      rr_q        <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc_ev && (rr_q == IW'(i))) begin
        tag_q[i] <= upd_pc;
        tgt_q[i] <= upd_tgt;
      end else if (retarget_ev && upd_match[i]) begin
        tgt_q[i] <= upd_tgt;
      end
    end
  end

  // R1: an address never lives in two entries
  p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));

  // R7: the claimed slot now holds the branch that missed
  p_alloc_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ev |=> (vld_q[$past(rr_q)] && (tag_q[$past(rr_q)] == $past(upd_pc))
                  && (tgt_q[$past(rr_q)] == $past(upd_tgt))));

  // R8: a not-taken miss claims nothing
  p_no_alloc_nt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !upd_hit) |=> ($stable(vld_q) && $stable(rr_q)));

endmodule

// File: rtl/bpred_dir.sv
module bpred_dir
  import bpred_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 512,
  parameter int IDX_LO  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] look_pc,
  output logic            look_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int IW = $clog2(ENTRIES);

  ctr_t          ctr_q [ENTRIES];
  logic [IW-1:0] look_idx;
  logic [IW-1:0] upd_idx;

  assign look_idx   = look_pc[IDX_LO +: IW];
  assign upd_idx    = upd_pc[IDX_LO +: IW];
  assign look_taken = ctr_leans_taken(ctr_q[look_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_RESET;
    end else if (upd_valid) begin
      ctr_q[upd_idx] <= ctr_step(ctr_q[upd_idx], upd_taken);
    end
  end

  // R5: holds at the top
  p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && (ctr_q[upd_idx] == 2'd3)) |=> (ctr_q[$past(upd_idx)] == 2'd3));

  // R5: holds at the bottom
  p_sat_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && (ctr_q[upd_idx] == 2'd0)) |=> (ctr_q[$past(upd_idx)] == 2'd0));

endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int BTC_ENTRIES = 64,
  parameter int DIR_ENTRIES = 512,
  parameter int FETCH_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_next_pc,
  output logic            pred_taken,
  output logic            pred_hit,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target
);
  localparam int IDX_LO = $clog2(FETCH_BYTES);

  logic            btc_hit;
  logic [PC_W-1:0] btc_tgt;
  logic            dir_taken;
  logic [PC_W-1:0] seq_pc;

  bpred_btc #(.PC_W(PC_W), .ENTRIES(BTC_ENTRIES)) u_btc (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_pc   (fetch_pc),
    .look_hit  (btc_hit),
    .look_tgt  (btc_tgt),
    .upd_valid (res_valid),
    .upd_pc    (res_pc),
    .upd_taken (res_taken),
    .upd_tgt   (res_target)
  );

  bpred_dir #(.PC_W(PC_W), .ENTRIES(DIR_ENTRIES), .IDX_LO(IDX_LO)) u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_pc    (fetch_pc),
    .look_taken (dir_taken),
    .upd_valid  (res_valid),
    .upd_pc     (res_pc),
    .upd_taken  (res_taken)
  );

  assign seq_pc       = fetch_pc + PC_W'(FETCH_BYTES);
  assign pred_hit     = btc_hit;
  assign pred_taken   = btc_hit && dir_taken;
  assign pred_next_pc = pred_taken ? btc_tgt : seq_pc;

  // R9: without a resolution the prediction for an unchanged address holds
  p_hold_without_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(res_valid) && $stable(fetch_pc)) |->
      ($stable(pred_next_pc) && $stable(pred_taken) && $stable(pred_hit)));

endmodule

// File: tb/bpred_top_bench.sv
module bpred_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] pred_next_pc;
  logic        pred_taken;
  logic        pred_hit;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bpred_top u_bpred_top (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_next_pc(pred_next_pc), .pred_taken(pred_taken), .pred_hit(pred_hit),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target)
  );

  // Behavioural model: oldest allocation at the front of the queue.
  typedef struct { logic [31:0] pc; logic [31:0] tgt; } ent_t;
  ent_t m_q[$];
  int   m_ctr[int];

  function automatic int m_cnt(input logic [31:0] pc);
    int k = int'((pc >> 2) % 512);
    return m_ctr.exists(k) ? m_ctr[k] : 1;
  endfunction

  function automatic int m_find(input logic [31:0] pc);
    foreach (m_q[i]) if (m_q[i].pc == pc) return i;
    return -1;
  endfunction

  task automatic m_update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
    int k = int'((pc >> 2) % 512);
    int c = m_cnt(pc);
    int f = m_find(pc);
    ent_t e;
    if (tk) c = (c < 3) ? c + 1 : 3;
    else    c = (c > 0) ? c - 1 : 0;
    m_ctr[k] = c;
    if (tk) begin
      if (f >= 0) m_q[f].tgt = tg;
      else begin
        if (m_q.size() == 64) void'(m_q.pop_front());
        e.pc = pc; e.tgt = tg;
        m_q.push_back(e);
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s pc=%h actual=%h expected=%h", tag, what, fetch_pc, act, exp);
    end
  endtask

  // One cycle: drive, settle, compare, then let the edge apply the resolution.
  task automatic step(input string tag, input logic [31:0] fpc, input logic rv,
                      input logic [31:0] rpc, input logic rtk, input logic [31:0] rtg);
    int f;
    logic ehit, etk;
    logic [31:0] enx;
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rtk; res_target = rtg;
    #1;
    f    = m_find(fpc);
    ehit = (f >= 0);
    etk  = ehit && (m_cnt(fpc) >= 2);
    enx  = etk ? m_q[f].tgt : fpc + 32'd4;
    chk(tag, "hit", {31'd0, pred_hit}, {31'd0, ehit});
    chk(tag, "taken", {31'd0, pred_taken}, {31'd0, etk});
    chk(tag, "next_pc", pred_next_pc, enx);
    @(posedge clk);
    if (rv) m_update(rpc, rtk, rtg);
    @(negedge clk);
  endtask

  task automatic look(input string tag, input logic [31:0] fpc);
    step(tag, fpc, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic resolve(input string tag, input logic [31:0] rpc, input logic rtk, input logic [31:0] rtg);
    step(tag, rpc, 1'b1, rpc, rtk, rtg);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: empty after reset
    look("R10", 32'h0000_0100);
    look("R10", 32'h0000_0000);
    // R4: miss gives sequential address
    look("R4", 32'h0000_0200);

    // R9: lookup during the allocating update still misses, next cycle hits
    step("R9", 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0800);
    // R2: hit with counter 2 predicts the stored target
    look("R2", 32'h0000_0100);
    // R3: counter back to 1 overrides the hit
    resolve("R3", 32'h0000_0100, 1'b0, 32'h0000_0104);
    look("R3", 32'h0000_0100);

    // R5: saturation in both directions
    for (int i = 0; i < 5; i++) resolve("R5", 32'h0000_0100, 1'b1, 32'h0000_0800);
    resolve("R5", 32'h0000_0100, 1'b0, 32'h0000_0104);
    look("R5", 32'h0000_0100);
    for (int i = 0; i < 5; i++) resolve("R5", 32'h0000_0100, 1'b0, 32'h0000_0104);
    resolve("R5", 32'h0000_0100, 1'b1, 32'h0000_0800);
    look("R5", 32'h0000_0100);

    // R6: a branch 0x800 away shares the counter
    resolve("R6", 32'h0000_0900, 1'b1, 32'h0000_0a00);
    resolve("R6", 32'h0000_0900, 1'b1, 32'h0000_0a00);
    look("R6", 32'h0000_0100);
    look("R6", 32'h0000_0900);

    // R8: not-taken miss allocates nothing; not-taken hit keeps the target
    resolve("R8", 32'h0000_0300, 1'b0, 32'h0000_0400);
    look("R8", 32'h0000_0300);
    resolve("R8", 32'h0000_0100, 1'b0, 32'h0000_0eee);
    resolve("R8", 32'h0000_0100, 1'b1, 32'h0000_0800);
    look("R8", 32'h0000_0100);

    // R7: retarget on a taken hit
    resolve("R7", 32'h0000_0100, 1'b1, 32'h0000_0c00);
    look("R7", 32'h0000_0100);

    // R7: fill past capacity, the oldest allocations go first
    for (int i = 0; i < 70; i++)
      resolve("R7", 32'h0000_4000 + 32'(i) * 4, 1'b1, 32'h0001_0000 + 32'(i) * 16);
    look("R7", 32'h0000_0100);
    look("R7", 32'h0000_0900);
    look("R7", 32'h0000_4000);
    look("R7", 32'h0000_4014);
    look("R7", 32'h0000_4018);
    for (int i = 0; i < 70; i++) look("R7", 32'h0000_4000 + 32'(i) * 4);

    // R1: random mixed traffic over a small aliasing address pool
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = 32'h0000_1000 + (($urandom % 40) * 4) + (($urandom % 2) * 32'h800);
      b = 32'h0000_1000 + (($urandom % 40) * 4) + (($urandom % 2) * 32'h800);
      if (($urandom % 3) != 0)
        step("R1", a, 1'b1, (($urandom % 2) != 0) ? a : b, ($urandom % 4) != 0,
             32'h0002_0000 + (($urandom % 8) * 4));
      else
        look("R1", a);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule